// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit CPU. Thirteen request lines come in: two external pins, two timers, one serial port and eight port-pin lines. A request takes part in arbitration only when its own enable bit and the global enable are both set. Each line also carries a priority bit that puts it at the high or the low level. The winning request is presented to the CPU as a registered request flag together with a vector index that is unique to each source.

The block keeps one in-service flag for each level, so service routines can nest. The CPU pulses an acknowledge strobe when it takes the presented interrupt. That marks the winner's level as in service. A return strobe closes the most urgent routine that is open. While a high-level routine runs, nothing is presented. While only a low-level routine runs, a high-level request can still preempt it. Clearing request flags at their source is left to the surrounding logic.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Sources and the vector index they produce on `vec_o`: ext0=0, ext1=1, timer0=2, timer1=3, serial=4, port pins 2..9 = 5..12. Bit k of `req_i`, `en_i` and `prio_i` belongs to the source with vector k. `vec_o` reads 0 whenever `irq_o` is low.
- R2: A source is eligible only when `req_i[k]`, `en_i[k]` and `glob_en_i` are all 1. With no eligible source, `irq_o` stays low.
- R3: `prio_i[k]`=1 puts source k at the high level. An eligible high-level source that is not blocked wins over every low-level source.
- R4: Within one level, the first eligible source in this polling order wins: 0, 4, 8, 2, 9, 1, 5, 10, 3, 6, 11, 7, 12.
- R5: `irq_o` and `vec_o` are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R6: `ack_i` sampled while `irq_o` is high marks the presented request's level as in service. `ack_i` while `irq_o` is low has no effect.
- R7: Low-level requests are blocked while any level is in service. High-level requests are blocked while the high level is in service, so a high-level request preempts a running low-level routine.
- R8: `reti_i` clears the high in-service flag if it is set, and otherwise clears the low one. With neither set, `reti_i` has no effect.
- R9: While `rst_n` is low, `irq_o` is 0, `vec_o` is 0 and neither level is in service.
- R10: When `ack_i` and `reti_i` arrive in the same cycle, the return is applied first and the acknowledge second. The request presented at that edge is computed from the resulting in-service state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 13 | Request line per source |
| en_i | input | 13 | Enable bit per source |
| glob_en_i | input | 1 | Global enable |
| prio_i | input | 13 | Priority bit per source, 1 = high level |
| ack_i | input | 1 | CPU has taken the presented interrupt |
| reti_i | input | 1 | CPU returns from a service routine |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 4 | Vector index of the presented request |

## Verification
The arbitration is first tried with all thirteen requests asserted at one level, removing the current winner each time. This walk separates a correct polling order from any other permutation. Mixed-priority patterns then show whether the level bit outranks the polling position. Ack and return sequences that open a low routine, preempt it, and unwind it one step at a time distinguish per-level blocking from a single busy flag and from a return that clears the wrong level. A long random run with random acknowledges and returns is compared every cycle against a behavioural model, which exposes latency and same-cycle ack/return ordering errors.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 13;
  localparam int VEC_W   = $clog2(NUM_SRC);

  // Source index that sits at a given polling position (0 = polled first).
  function automatic int poll_src(input int pos);
    case (pos)
      0:  return 0;
      1:  return 4;
      2:  return 8;
      3:  return 2;
      4:  return 9;
      5:  return 1;
      6:  return 5;
      7:  return 10;
      8:  return 3;
      9:  return 6;
      10: return 11;
      11: return 7;
      default: return 12;
    endcase
  endfunction

  // In-service update: return closes the highest open level, then ack opens one.
  function automatic logic [1:0] svc_next(input logic [1:0] cur, input logic reti,
                                          input logic ack, input logic ack_hi);
    logic [1:0] n;
    n = cur;
    if (reti) begin
      if (n[1]) n[1] = 1'b0;
      else      n[0] = 1'b0;
    end
    if (ack) begin
      if (ack_hi) n[1] = 1'b1;
      else        n[0] = 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/irq_poll_pick.sv
module irq_poll_pick
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = VEC_W
) (
  input  logic [N-1:0] cand_i,
  output logic         hit_o,
  output logic [W-1:0] src_o
);
  always_comb begin
    hit_o = 1'b0;
    src_o = '0;
    for (int p = N - 1; p >= 0; p--) begin
      if (cand_i[poll_src(p)]) begin
        hit_o = 1'b1;
        src_o = W'(poll_src(p));
      end
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_take_i,
  input  logic ack_hi_i,
  input  logic reti_i,
  output logic hi_q_o,
  output logic lo_q_o,
  output logic hi_nxt_o,
  output logic lo_nxt_o
);
  logic [1:0] svc_q;
  logic [1:0] svc_d;

  assign svc_d = svc_next(svc_q, reti_i, ack_take_i, ack_hi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 2'b00;
    else        svc_q <= svc_d;
  end

  assign hi_q_o   = svc_q[1];
  assign lo_q_o   = svc_q[0];
  assign hi_nxt_o = svc_d[1];
  assign lo_nxt_o = svc_d[0];
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               glob_en_i,
  input  logic [NUM_SRC-1:0] prio_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_SRC-1:0] eligible;
  logic               hi_hit, lo_hit;
  logic [VEC_W-1:0]   hi_src, lo_src;
  logic               ins_hi, ins_lo, ins_hi_nxt, ins_lo_nxt;
  logic               take_hi, take_lo;
  logic               irq_q, pend_hi;
  logic [VEC_W-1:0]   vec_q;
  logic               ack_take;

  assign eligible = req_i & en_i & {NUM_SRC{glob_en_i}};
  assign ack_take = ack_i & irq_q;

  irq_poll_pick #(.N(NUM_SRC), .W(VEC_W)) u_pick_hi (
    .cand_i (eligible & prio_i),
    .hit_o  (hi_hit),
    .src_o  (hi_src)
  );

  irq_poll_pick #(.N(NUM_SRC), .W(VEC_W)) u_pick_lo (
    .cand_i (eligible & ~prio_i),
    .hit_o  (lo_hit),
    .src_o  (lo_src)
  );

  irq_svc_track u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_take_i (ack_take),
    .ack_hi_i   (pend_hi),
    .reti_i     (reti_i),
    .hi_q_o     (ins_hi),
    .lo_q_o     (ins_lo),
    .hi_nxt_o   (ins_hi_nxt),
    .lo_nxt_o   (ins_lo_nxt)
  );

  assign take_hi = hi_hit & ~ins_hi_nxt;
  assign take_lo = ~take_hi & lo_hit & ~ins_hi_nxt & ~ins_lo_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      vec_q   <= '0;
      pend_hi <= 1'b0;
    end else begin
      irq_q   <= take_hi | take_lo;
      vec_q   <= take_hi ? hi_src : (take_lo ? lo_src : '0);
      pend_hi <= take_hi;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic               glob_en_i,
  input logic               ack_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               ins_hi,
  input logic               ins_lo,
  input logic               pend_hi
);
  a_r2_glob_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_i |=> !irq_o);

  a_r2_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i & en_i) == '0) |=> !irq_o);

  a_r1_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0));

  a_r7_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !irq_o);

  a_r7_lo_blocks_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo && irq_o) |-> pend_hi);

  a_r6_ack_opens_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && pend_hi) |=> ins_hi);

  a_r6_ack_opens_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !pend_hi && !reti_i) |=> ins_lo);

  a_r8_reti_closes_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && ins_hi) |=> !ins_hi);

  a_r8_reti_idle_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && !ins_hi && !ins_lo) |=> (!ins_hi && !ins_lo));
endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .en_i      (en_i),
  .glob_en_i (glob_en_i),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .ins_hi    (ins_hi),
  .ins_lo    (ins_lo),
  .pend_hi   (pend_hi)
);

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  localparam int CLK_P = 10;
  localparam int NS = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0, en = '0, prio = '0;
  logic          glob = 1'b0, ack = 1'b0, reti = 1'b0;
  logic          irq_o;
  logic [3:0]    vec_o;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R9";
  bit done = 0;

  // Polling order as given by R4.
  int order[NS] = '{0, 4, 8, 2, 9, 1, 5, 10, 3, 6, 11, 7, 12};

  // Behavioural reference state.
  bit m_hi, m_lo, e_irq, e_lvl;
  int e_vec;

  irq_nest_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .glob_en_i(glob),
    .prio_i(prio), .ack_i(ack), .reti_i(reti), .irq_o(irq_o), .vec_o(vec_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; e_irq = 0; e_lvl = 0; e_vec = 0;
    end else begin
      int pick;
      bit plvl;
      if (reti) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
      if (ack && e_irq) begin
        if (e_lvl) m_hi = 1; else m_lo = 1;
      end
      pick = -1; plvl = 0;
      if (!m_hi) begin
        foreach (order[i]) if (pick < 0 && glob && req[order[i]] && en[order[i]] && prio[order[i]]) begin
          pick = order[i]; plvl = 1;
        end
        if (pick < 0 && !m_lo)
          foreach (order[i]) if (pick < 0 && glob && req[order[i]] && en[order[i]] && !prio[order[i]])
            pick = order[i];
      end
      e_irq = (pick >= 0);
      e_lvl = plvl;
      e_vec = (pick >= 0) ? pick : 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Advance one clock and compare outputs with the model away from the edge.
  task automatic step();
    @(posedge clk);
    #1;
    chk({cur_req, " irq"}, int'(irq_o), int'(e_irq));
    chk({cur_req, " vec"}, int'(vec_o), e_vec);
  endtask

  task automatic pulse_ack(); ack = 1; step(); ack = 0; endtask
  task automatic pulse_reti(); reti = 1; step(); reti = 0; endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq in reset", int'(irq_o), 0);
    chk("R9 vec in reset", int'(vec_o), 0);
    rst_n = 1;
    step();

    // R2: enables gate eligibility
    cur_req = "R2";
    req = '1; en = '0; glob = 1; step(); step();
    chk("R2 no enable", int'(irq_o), 0);
    en = '1; glob = 0; step(); step();
    chk("R2 global off", int'(irq_o), 0);

    // R5: output waits for the edge
    cur_req = "R5";
    glob = 1; #1;
    chk("R5 no change before edge", int'(irq_o), 0);
    step();
    chk("R5 after edge", int'(irq_o), 1);

    // R4: peel off winners one by one in polling order
    cur_req = "R4";
    req = '1; prio = '0;
    foreach (order[i]) begin
      step();
      chk("R4 poll order", int'(vec_o), order[i]);
      req[order[i]] = 1'b0;
    end
    step();
    chk("R1 idle vec", int'(vec_o), 0);

    // R3: level outranks position
    cur_req = "R3";
    req = '1; prio = '0; prio[3] = 1; step();
    chk("R3 high wins", int'(vec_o), 3);

    // R6/R7/R8: nesting
    cur_req = "R7";
    pulse_ack();
    chk("R7 high in service blocks", int'(irq_o), 0);
    cur_req = "R8";
    pulse_reti();
    chk("R8 high closed", int'(vec_o), 3);

    cur_req = "R7";
    prio = '0; prio[12] = 1; req = '0; req[4] = 1; step();
    chk("R1 serial vec", int'(vec_o), 4);
    pulse_ack();
    chk("R7 low in service blocks low", int'(irq_o), 0);
    req[12] = 1; step();
    chk("R7 high preempts low", int'(vec_o), 12);
    pulse_ack();
    chk("R7 nested high blocks", int'(irq_o), 0);
    req[12] = 0;
    cur_req = "R8";
    pulse_reti();
    chk("R8 low still open", int'(irq_o), 0);
    pulse_reti();
    chk("R8 low closed", int'(vec_o), 4);
    pulse_reti();
    chk("R8 idle return ignored", int'(vec_o), 4);

    cur_req = "R6";
    en = '0; step();
    pulse_ack();
    en = '1; step();
    chk("R6 ack while idle ignored", int'(vec_o), 4);

    // R10: same-cycle return and acknowledge
    cur_req = "R10";
    pulse_ack();
    prio[0] = 1; req[0] = 1; step();
    chk("R10 preempt ready", int'(vec_o), 0);
    ack = 1; reti = 1; step(); ack = 0; reti = 0;
    chk("R10 high opened", int'(irq_o), 0);
    req[0] = 0; pulse_reti();
    chk("R10 low was closed", int'(vec_o), 4);

    // Random traffic, compared with the model each cycle
    cur_req = "R5";
    for (int c = 0; c < 4000; c++) begin
      req  = NS'($urandom);
      en   = NS'($urandom) | NS'($urandom);
      prio = NS'($urandom);
      glob = ($urandom % 8) != 0;
      ack  = ($urandom % 3) == 0;
      reti = ($urandom % 4) == 0;
      step();
    end
    ack = 0; reti = 0;
    step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule